// File: doc/BRIEF.md
# Bit-Serial Word Port Adapter

This block sits between a one-bit-wide, burst-oriented memory-mapped data port and a 32-bit word array. On the serial side, the burst count is given in bits, not in words. To program a word, the master sends exactly 32 write beats, most significant bit first. The adapter packs these bits into one word and issues a single-word program to the array. To read, the master gives a start address and a burst count that is a whole multiple of 32 bits. The adapter fetches words from incrementing addresses and returns each one bit per beat, with a valid strobe, starting at bit 31.

Every command is checked before the array is touched:

- the burst count is checked against the legal values for its direction;
- the word address is checked against the array depth;
- the address's sector is checked against two per-sector protection vectors, one for writes and one for reads.

A program command that fails any check still absorbs its beats but writes nothing. A read word that fails returns all-ones beats, so a master waiting for data never hangs. A two-bit busy code and two result flags (write success and read success) are driven toward a neighbouring status unit.

Top module: `serial_word_port`

## Requirements
- R1: After reset, busy is 00, waitrequest, read-valid and array request are low, and both result flags are 0.
- R2: A program command with burst count 32 to an in-range, unprotected word takes 32 beats (the first beat is bit 31, the last is bit 0). It then issues one array write of the packed word to that address, and sets the write-success flag to 1.
- R3: A program command whose burst count is not 32 has its beats accepted without stall. It makes no array request and clears the write-success flag.
- R4: A program command makes no array request and clears the write-success flag if either of these holds:
  - the word address is at or above DEPTH;
  - the address's sector has its write-protect or read-protect bit set. The sector index is the address divided by SECT_WORDS, and it selects that bit of each protection vector.
- R5: The busy code is 10 from the first accepted program beat until the program completes, 11 while a read is in progress, and 00 when idle; 01 never appears.
- R6: Waitrequest is low in idle and throughout the beats of a program burst. It is high while an array access is pending and while read data is being returned. An array request, once raised, holds its address, direction and write data until the array acknowledges it.
- R7: A read with burst count 32·N (1 ≤ N ≤ MAX_WORDS) returns 32·N valid beats. These carry N words from consecutive increasing addresses, each word most significant bit first. On success the read-success flag is set to 1.
- R8: A read whose burst count is 0, not a multiple of 32, or above 32·MAX_WORDS returns no valid beats, makes no array request and clears the read-success flag.
- R9: A read word in a sector whose read-protect bit is set returns 32 one-beats with no array request, and clears the read-success flag. Other words of the same burst return real data. A write-protect bit alone does not block reads.
- R10: A read burst that runs past the last word returns real data up to the last word and all-ones beats beyond it, and clears the read-success flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_addr | input | AW | Word start address of a command |
| sp_read | input | 1 | Read command request |
| sp_write | input | 1 | Program beat request |
| sp_wbit | input | 1 | Serial write data bit |
| sp_burst | input | BCW | Burst count in bits |
| sp_wait | output | 1 | Waitrequest: beat or command not accepted |
| sp_rvalid | output | 1 | Read beat valid |
| sp_rbit | output | 1 | Serial read data bit |
| wprot | input | NSECT | Per-sector write-protect bits |
| rprot | input | NSECT | Per-sector read-protect bits |
| arr_req | output | 1 | Array access request, held until acknowledged |
| arr_we | output | 1 | Array access is a write |
| arr_addr | output | AW | Array word address |
| arr_wdata | output | DW | Array write word |
| arr_ack | input | 1 | Array acknowledge; read data valid in the same cycle |
| arr_rdata | input | DW | Array read word |
| busy | output | 2 | Busy code: 00 idle, 10 program, 11 read |
| wr_ok | output | 1 | Result of the last program command |
| rd_ok | output | 1 | Result of the last read command |

## Verification
A bit counter that is off by one shows up at the ports in the same burst. A program would reach the array one beat early or late, with a shifted word. A read would return a beat count other than 32 per word, visible on the valid strobe before the next command. A stale address register shows on the first array access of the next burst, as the wrong word in memory or in the read stream. A lost guard decision shows within a few cycles of the command: as an unexpected array access counted by the bench's array model, or as a wrong result flag once busy returns to 00.

// File: rtl/swp_pkg.sv
package swp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PCOLLECT,
      ST_PISSUE,
      ST_PSINK,
      ST_RFETCH,
      ST_RSHIFT
   } swp_state_e;

   localparam logic [1:0] BUSY_NONE = 2'b00;
   localparam logic [1:0] BUSY_PROG = 2'b10;
   localparam logic [1:0] BUSY_READ = 2'b11;

endpackage

// File: rtl/swp_guard.sv
module swp_guard #(
   parameter int DW         = 32,
   parameter int DEPTH      = 200,
   parameter int SECT_WORDS = 64,
   parameter int MAX_WORDS  = 128,
   localparam int AW    = $clog2(DEPTH),
   localparam int BCW   = $clog2(MAX_WORDS * DW + 1),
   localparam int NSECT = (DEPTH + SECT_WORDS - 1) / SECT_WORDS,
   localparam int LDW   = $clog2(DW),
   localparam int SB    = $clog2(SECT_WORDS)
) (
   input  logic [AW:0]      chk_addr,
   input  logic [BCW-1:0]   burst,
   input  logic [NSECT-1:0] wprot,
   input  logic [NSECT-1:0] rprot,
   output logic             rd_allow,
   output logic             wr_allow,
   output logic             pburst_ok,
   output logic             rburst_ok
);

   logic in_range;
   logic sect_wp;
   logic sect_rp;

   assign in_range = chk_addr < (AW+1)'(DEPTH);

   // sector lookup: a single sector needs no index bits
   generate
      if (NSECT == 1) begin : g_one_sect
         assign sect_wp = wprot[0];
         assign sect_rp = rprot[0];
      end else begin : g_many_sect
         localparam int IW   = AW - SB;
         localparam int PADW = 1 << IW;
         logic [PADW-1:0] wp_pad;
         logic [PADW-1:0] rp_pad;
         logic [IW-1:0]   idx;
         assign wp_pad  = PADW'(wprot);
         assign rp_pad  = PADW'(rprot);
         assign idx     = chk_addr[AW-1:SB];
         assign sect_wp = wp_pad[idx];
         assign sect_rp = rp_pad[idx];
      end
   endgenerate

   assign rd_allow  = in_range && !sect_rp;
   assign wr_allow  = in_range && !sect_rp && !sect_wp;
   assign pburst_ok = burst == BCW'(DW);
   assign rburst_ok = (burst != '0) && (burst[LDW-1:0] == '0)
                      && (burst <= BCW'(MAX_WORDS * DW));

endmodule

// File: rtl/swp_shift.sv
module swp_shift #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] ld_word,
   input  logic          shin,
   input  logic          shin_bit,
   input  logic          shout,
   output logic [DW-1:0] word,
   output logic          msb
);

   logic [DW-1:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sr <= '0;
      else if (load)
         sr <= ld_word;
      else if (shin)
         sr <= {sr[DW-2:0], shin_bit};
      else if (shout)
         sr <= {sr[DW-2:0], 1'b1};
   end

   assign word = sr;
   assign msb  = sr[DW-1];

endmodule

// File: rtl/swp_ctrl.sv
module swp_ctrl
   import swp_pkg::*;
#(
   parameter int DW        = 32,
   parameter int DEPTH     = 200,
   parameter int MAX_WORDS = 128,
   localparam int AW  = $clog2(DEPTH),
   localparam int BCW = $clog2(MAX_WORDS * DW + 1),
   localparam int WCW = $clog2(MAX_WORDS + 1),
   localparam int LDW = $clog2(DW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sp_read,
   input  logic           sp_write,
   input  logic [AW-1:0]  sp_addr,
   input  logic [BCW-1:0] sp_burst,
   input  logic           rd_allow,
   input  logic           wr_allow,
   input  logic           pburst_ok,
   input  logic           rburst_ok,
   input  logic           arr_ack,
   output logic [AW:0]    chk_addr,
   output logic           sp_wait,
   output logic           sp_rvalid,
   output logic           arr_req,
   output logic           arr_we,
   output logic [AW-1:0]  arr_addr,
   output logic [1:0]     busy,
   output logic           wr_ok,
   output logic           rd_ok,
   output logic           sh_load,
   output logic           sh_ones,
   output logic           sh_in,
   output logic           sh_out
);

   swp_state_e     state;
   logic [AW:0]    cur_addr;
   logic [WCW-1:0] words_left;
   logic [LDW-1:0] bit_cnt;
   logic [BCW-1:0] sink_left;
   logic           last_bit;

   assign last_bit  = bit_cnt == LDW'(DW - 1);
   assign chk_addr  = (state == ST_IDLE) ? {1'b0, sp_addr} : cur_addr;
   assign arr_addr  = cur_addr[AW-1:0];
   assign sp_wait   = !(state inside {ST_IDLE, ST_PCOLLECT, ST_PSINK});
   assign sp_rvalid = state == ST_RSHIFT;
   assign arr_we    = state == ST_PISSUE;
   assign arr_req   = (state == ST_PISSUE) || ((state == ST_RFETCH) && rd_allow);
   assign sh_in     = ((state == ST_IDLE) && sp_write && pburst_ok && wr_allow)
                      || ((state == ST_PCOLLECT) && sp_write);
   assign sh_load   = (state == ST_RFETCH) && (!rd_allow || arr_ack);
   assign sh_ones   = !rd_allow;
   assign sh_out    = state == ST_RSHIFT;

   always_comb begin
      case (state)
         ST_PCOLLECT, ST_PISSUE, ST_PSINK: busy = BUSY_PROG;
         ST_RFETCH, ST_RSHIFT:             busy = BUSY_READ;
         default:                          busy = BUSY_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cur_addr   <= '0;
         words_left <= '0;
         bit_cnt    <= '0;
         sink_left  <= '0;
         wr_ok      <= 1'b0;
         rd_ok      <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (sp_write) begin
                  cur_addr <= {1'b0, sp_addr};
                  if (pburst_ok && wr_allow) begin
                     bit_cnt <= LDW'(1);
                     state   <= ST_PCOLLECT;
                  end else if (sp_burst <= BCW'(1)) begin
                     wr_ok <= 1'b0;
                  end else begin
                     sink_left <= sp_burst - BCW'(1);
                     state     <= ST_PSINK;
                  end
               end else if (sp_read) begin
                  cur_addr <= {1'b0, sp_addr};
                  if (rburst_ok) begin
                     words_left <= WCW'(sp_burst >> LDW);
                     bit_cnt    <= '0;
                     rd_ok      <= 1'b1;
                     state      <= ST_RFETCH;
                  end else begin
                     rd_ok <= 1'b0;
                  end
               end
            end
            ST_PCOLLECT: begin
               if (sp_write) begin
                  bit_cnt <= bit_cnt + LDW'(1);
                  if (last_bit) state <= ST_PISSUE;
               end
            end
            ST_PISSUE: begin
               if (arr_ack) begin
                  wr_ok <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_PSINK: begin
               if (sp_write) begin
                  sink_left <= sink_left - BCW'(1);
                  if (sink_left == BCW'(1)) begin
                     wr_ok <= 1'b0;
                     state <= ST_IDLE;
                  end
               end
            end
            ST_RFETCH: begin
               if (!rd_allow) begin
                  rd_ok <= 1'b0;
                  state <= ST_RSHIFT;
               end else if (arr_ack) begin
                  state <= ST_RSHIFT;
               end
            end
            ST_RSHIFT: begin
               bit_cnt <= bit_cnt + LDW'(1);
               if (last_bit) begin
                  cur_addr   <= cur_addr + (AW+1)'(1);
                  words_left <= words_left - WCW'(1);
                  state      <= (words_left == WCW'(1)) ? ST_IDLE : ST_RFETCH;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/serial_word_port.sv
module serial_word_port #(
   parameter int DW         = 32,
   parameter int DEPTH      = 200,
   parameter int SECT_WORDS = 64,
   parameter int MAX_WORDS  = 128,
   localparam int AW    = $clog2(DEPTH),
   localparam int BCW   = $clog2(MAX_WORDS * DW + 1),
   localparam int NSECT = (DEPTH + SECT_WORDS - 1) / SECT_WORDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    sp_addr,
   input  logic             sp_read,
   input  logic             sp_write,
   input  logic             sp_wbit,
   input  logic [BCW-1:0]   sp_burst,
   output logic             sp_wait,
   output logic             sp_rvalid,
   output logic             sp_rbit,
   input  logic [NSECT-1:0] wprot,
   input  logic [NSECT-1:0] rprot,
   output logic             arr_req,
   output logic             arr_we,
   output logic [AW-1:0]    arr_addr,
   output logic [DW-1:0]    arr_wdata,
   input  logic             arr_ack,
   input  logic [DW-1:0]    arr_rdata,
   output logic [1:0]       busy,
   output logic             wr_ok,
   output logic             rd_ok
);

   if (DW < 2 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("DW must be a power of two of at least 2");
   end
   if (SECT_WORDS < 1 || (SECT_WORDS & (SECT_WORDS - 1)) != 0 || SECT_WORDS > DEPTH) begin : g_bad_sect
      $error("SECT_WORDS must be a power of two no larger than DEPTH");
   end
   if (DEPTH < 2 || MAX_WORDS < 1) begin : g_bad_size
      $error("DEPTH must be at least 2 and MAX_WORDS at least 1");
   end

   logic [AW:0]   chk_addr;
   logic          rd_allow, wr_allow, pburst_ok, rburst_ok;
   logic          sh_load, sh_ones, sh_in, sh_out;
   logic [DW-1:0] ld_word;

   swp_guard #(.DW(DW), .DEPTH(DEPTH), .SECT_WORDS(SECT_WORDS), .MAX_WORDS(MAX_WORDS)) u_guard (
      .chk_addr  (chk_addr),
      .burst     (sp_burst),
      .wprot     (wprot),
      .rprot     (rprot),
      .rd_allow  (rd_allow),
      .wr_allow  (wr_allow),
      .pburst_ok (pburst_ok),
      .rburst_ok (rburst_ok)
   );

   swp_ctrl #(.DW(DW), .DEPTH(DEPTH), .MAX_WORDS(MAX_WORDS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sp_read   (sp_read),
      .sp_write  (sp_write),
      .sp_addr   (sp_addr),
      .sp_burst  (sp_burst),
      .rd_allow  (rd_allow),
      .wr_allow  (wr_allow),
      .pburst_ok (pburst_ok),
      .rburst_ok (rburst_ok),
      .arr_ack   (arr_ack),
      .chk_addr  (chk_addr),
      .sp_wait   (sp_wait),
      .sp_rvalid (sp_rvalid),
      .arr_req   (arr_req),
      .arr_we    (arr_we),
      .arr_addr  (arr_addr),
      .busy      (busy),
      .wr_ok     (wr_ok),
      .rd_ok     (rd_ok),
      .sh_load   (sh_load),
      .sh_ones   (sh_ones),
      .sh_in     (sh_in),
      .sh_out    (sh_out)
   );

   assign ld_word = sh_ones ? '1 : arr_rdata;

   swp_shift #(.DW(DW)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .ld_word  (ld_word),
      .shin     (sh_in),
      .shin_bit (sp_wbit),
      .shout    (sh_out),
      .word     (arr_wdata),
      .msb      (sp_rbit)
   );

endmodule

// File: rtl/swp_chk.sv
module swp_chk #(
   parameter int DW = 32,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sp_wait,
   input logic          sp_rvalid,
   input logic          arr_req,
   input logic          arr_we,
   input logic          arr_ack,
   input logic [AW-1:0] arr_addr,
   input logic [DW-1:0] arr_wdata,
   input logic [1:0]    busy
);

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req && !arr_ack |=> arr_req && $stable(arr_addr) && $stable(arr_we));

   // R6
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req && arr_we && !arr_ack |=> $stable(arr_wdata));

   // R6
   req_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req |-> sp_wait);

   // R5
   rvalid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_rvalid |-> busy == 2'b11);

   // R5
   busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy != 2'b01);

   // R2
   write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req && arr_we |-> busy == 2'b10);

endmodule

bind serial_word_port swp_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sp_wait   (sp_wait),
   .sp_rvalid (sp_rvalid),
   .arr_req   (arr_req),
   .arr_we    (arr_we),
   .arr_ack   (arr_ack),
   .arr_addr  (arr_addr),
   .arr_wdata (arr_wdata),
   .busy      (busy)
);

// File: tb/sim_serial_word_port.sv
module sim_serial_word_port;

   localparam int CLK_P = 10;
   localparam int DW    = 32;
   localparam int DEPTH = 200;
   localparam int SECT  = 64;
   localparam int MAXW  = 128;
   localparam int AW    = $clog2(DEPTH);
   localparam int BCW   = $clog2(MAXW * DW + 1);
   localparam int NSECT = (DEPTH + SECT - 1) / SECT;
   localparam int LAT   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] sp_addr = '0;
   logic sp_read = 1'b0, sp_write = 1'b0, sp_wbit = 1'b0;
   logic [BCW-1:0] sp_burst = '0;
   logic sp_wait, sp_rvalid, sp_rbit;
   logic [NSECT-1:0] wprot = '0, rprot = '0;
   logic arr_req, arr_we;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_wdata;
   logic arr_ack = 1'b0;
   logic [DW-1:0] arr_rdata = '0;
   logic [1:0] busy;
   logic wr_ok, rd_ok;

   int n_chk = 0, n_err = 0;
   int n_wr = 0, n_rd = 0, lat_cnt = 0;
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] got [8];
   int nbeats, stalls;
   bit saw_busy, wait_seen, wait_bad;

   always #(CLK_P / 2) clk = ~clk;

   serial_word_port #(.DW(DW), .DEPTH(DEPTH), .SECT_WORDS(SECT), .MAX_WORDS(MAXW)) u0 (
      .clk(clk), .rst_n(rst_n), .sp_addr(sp_addr), .sp_read(sp_read), .sp_write(sp_write),
      .sp_wbit(sp_wbit), .sp_burst(sp_burst), .sp_wait(sp_wait), .sp_rvalid(sp_rvalid),
      .sp_rbit(sp_rbit), .wprot(wprot), .rprot(rprot), .arr_req(arr_req), .arr_we(arr_we),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_ack(arr_ack), .arr_rdata(arr_rdata),
      .busy(busy), .wr_ok(wr_ok), .rd_ok(rd_ok)
   );

   function automatic logic [DW-1:0] pat(int a);
      return (DW'(a) * 32'h9E37_79B9) ^ 32'hC3A5_0F1E;
   endfunction

   // array model: acknowledges each request after LAT cycles
   always @(posedge clk) begin
      if (!rst_n) begin
         arr_ack <= 1'b0;
         lat_cnt <= 0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
      end else if (arr_req && !arr_ack) begin
         if (lat_cnt == LAT - 1) begin
            arr_ack <= 1'b1;
            lat_cnt <= 0;
            if (int'(arr_addr) < DEPTH) begin
               arr_rdata <= mem[arr_addr];
               if (arr_we) mem[arr_addr] <= arr_wdata;
            end
            if (arr_we) n_wr <= n_wr + 1;
            else        n_rd <= n_rd + 1;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end else begin
         arr_ack <= 1'b0;
         lat_cnt <= 0;
      end
   end

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_word(int a);
      if (a < DEPTH && !rprot[a / SECT]) return mem[a];
      return '1;
   endfunction

   task automatic prog(int addr, logic [DW-1:0] word, int burst);
      int i = 0;
      int t = 0;
      stalls = 0; saw_busy = 0; wait_seen = 0;
      @(negedge clk);
      sp_addr = AW'(addr); sp_burst = BCW'(burst); sp_write = 1'b1;
      while (i < burst && t < 500) begin
         sp_wbit = (i < DW) ? word[DW-1-i] : 1'b0;
         if (sp_wait) stalls++; else i++;
         @(negedge clk);
         t++;
         if (busy == 2'b10) saw_busy = 1;
      end
      sp_write = 1'b0;
      t = 0;
      while (busy != 2'b00 && t < 100) begin
         if (sp_wait) wait_seen = 1;
         @(negedge clk);
         t++;
      end
   endtask

   task automatic rd(int addr, int burst);
      int t = 0;
      nbeats = 0; saw_busy = 0; wait_bad = 0;
      for (int k = 0; k < 8; k++) got[k] = '0;
      @(negedge clk);
      sp_addr = AW'(addr); sp_burst = BCW'(burst); sp_read = 1'b1;
      while (sp_wait && t < 100) begin @(negedge clk); t++; end
      @(negedge clk);
      sp_read = 1'b0;
      t = 0;
      while (busy != 2'b00 && t < 3000) begin
         if (busy == 2'b11) saw_busy = 1;
         if (busy == 2'b11 && !sp_wait) wait_bad = 1;
         if (sp_rvalid) begin
            if (nbeats / DW < 8) got[nbeats / DW] = {got[nbeats / DW][DW-2:0], sp_rbit};
            nbeats++;
         end
         @(negedge clk);
         t++;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(busy == 2'b00, "R1", "busy", 64'(busy), 0);
      check(!sp_wait && !sp_rvalid && !arr_req, "R1", "wait/rvalid/req", {sp_wait, sp_rvalid, arr_req}, 0);
      check(!wr_ok && !rd_ok, "R1", "flags", {wr_ok, rd_ok}, 0);
   endtask

   task automatic t_prog_ok;
      int w0 = n_wr;
      prog(5, 32'hB00F_1E35, 32);
      check(mem[5] == 32'hB00F_1E35, "R2", "word written", mem[5], 32'hB00F_1E35);
      check(wr_ok == 1'b1, "R2", "wr_ok", wr_ok, 1);
      check(n_wr == w0 + 1, "R2", "array writes", n_wr - w0, 1);
      check(stalls == 0, "R6", "beat stalls", stalls, 0);
      check(wait_seen == 1, "R6", "wait while array busy", wait_seen, 1);
      check(saw_busy == 1, "R5", "busy 10 in program", saw_busy, 1);
   endtask

   task automatic t_read_single;
      int r0 = n_rd;
      rd(5, 32);
      check(nbeats == 32, "R7", "beats", nbeats, 32);
      check(got[0] == 32'hB00F_1E35, "R7", "word", got[0], 32'hB00F_1E35);
      check(rd_ok == 1'b1, "R7", "rd_ok", rd_ok, 1);
      check(n_rd == r0 + 1, "R7", "array reads", n_rd - r0, 1);
      check(saw_busy == 1, "R5", "busy 11 in read", saw_busy, 1);
      check(wait_bad == 0, "R6", "wait low during read", wait_bad, 0);
   endtask

   task automatic t_read_multi;
      rd(60, 96);
      check(nbeats == 96, "R7", "beats", nbeats, 96);
      for (int k = 0; k < 3; k++)
         check(got[k] == exp_word(60 + k), "R7", "word", got[k], exp_word(60 + k));
      check(rd_ok == 1'b1, "R7", "rd_ok", rd_ok, 1);
   endtask

   task automatic t_prog_badburst;
      int w0 = n_wr;
      logic [DW-1:0] m7 = mem[7];
      prog(7, 32'h0000_0000, 31);
      check(wr_ok == 1'b0, "R3", "wr_ok after 31", wr_ok, 0);
      check(stalls == 0, "R3", "beats absorbed", stalls, 0);
      prog(7, 32'h0000_0000, 64);
      check(wr_ok == 1'b0, "R3", "wr_ok after 64", wr_ok, 0);
      check(n_wr == w0 && mem[7] == m7, "R3", "no write", n_wr - w0, 0);
   endtask

   task automatic t_prog_protect;
      int w0;
      prog(9, 32'h1111_2222, 32);
      check(wr_ok == 1'b1, "R2", "wr_ok before protect", wr_ok, 1);
      w0 = n_wr;
      prog(200, 32'h1234_5678, 32);
      check(wr_ok == 1'b0, "R4", "out of range", wr_ok, 0);
      wprot = 4'b0010;
      prog(70, 32'h1234_5678, 32);
      check(wr_ok == 1'b0, "R4", "write-protected", wr_ok, 0);
      wprot = 4'b0000; rprot = 4'b0010;
      prog(70, 32'h1234_5678, 32);
      check(wr_ok == 1'b0, "R4", "read-protected", wr_ok, 0);
      check(n_wr == w0 && mem[70] == pat(70), "R4", "no write", n_wr - w0, 0);
      rprot = 4'b0000; wprot = 4'b0010;
      rd(70, 32);
      check(got[0] == pat(70) && rd_ok, "R9", "write-protect allows read", got[0], pat(70));
      wprot = 4'b0000;
      prog(70, 32'h1234_5678, 32);
      check(wr_ok == 1'b1 && mem[70] == 32'h1234_5678, "R4", "unprotected write", mem[70], 32'h1234_5678);
   endtask

   task automatic t_read_badburst;
      int r0 = n_rd;
      rd(5, 40);
      check(nbeats == 0 && rd_ok == 1'b0, "R8", "burst 40", nbeats, 0);
      rd(5, 32);
      rd(5, 0);
      check(nbeats == 0 && rd_ok == 1'b0, "R8", "burst 0", nbeats, 0);
      rd(5, 32);
      rd(5, MAXW * DW + 32);
      check(nbeats == 0 && rd_ok == 1'b0, "R8", "burst too long", nbeats, 0);
      check(n_rd == r0 + 2, "R8", "array reads", n_rd - r0, 2);
   endtask

   task automatic t_read_protect;
      int r0;
      rprot = 4'b0100;
      r0 = n_rd;
      rd(130, 32);
      check(nbeats == 32 && got[0] == '1, "R9", "protected word ones", got[0], 32'hFFFF_FFFF);
      check(rd_ok == 1'b0, "R9", "rd_ok", rd_ok, 0);
      check(n_rd == r0, "R9", "no array read", n_rd - r0, 0);
      r0 = n_rd;
      rd(126, 96);
      for (int k = 0; k < 3; k++)
         check(got[k] == exp_word(126 + k), "R9", "mixed burst word", got[k], exp_word(126 + k));
      check(n_rd == r0 + 2 && rd_ok == 1'b0, "R9", "mixed burst reads", n_rd - r0, 2);
      rprot = 4'b0000;
   endtask

   task automatic t_read_edge;
      rd(198, 128);
      check(nbeats == 128, "R10", "beats", nbeats, 128);
      for (int k = 0; k < 4; k++)
         check(got[k] == exp_word(198 + k), "R10", "edge word", got[k], exp_word(198 + k));
      check(rd_ok == 1'b0, "R10", "rd_ok", rd_ok, 0);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_prog_ok();
      t_read_single();
      t_read_multi();
      t_prog_badburst();
      t_prog_protect();
      t_read_badburst();
      t_read_protect();
      t_read_edge();
      repeat (5) @(negedge clk);
      summary();
      $finish;
   end

endmodule